// File: doc/BRIEF.md
# I2C Transmit Byte Queue with Acknowledge-Failure Halt

This block sits between the software data path and the byte engine of an I2C controller. It holds up to 64 outgoing bytes for a multi-byte write. While queue mode is on, each byte that software writes is stored in the queue. The block hands the bytes to the byte engine one at a time, in the order they were written. After each byte it waits for the engine to report that the acknowledge slot has ended, and it reads the acknowledge result that comes with that report.

If the target refuses a byte, the block stops draining and raises a sticky refusal flag. The bytes behind the refused one stay in the queue until a flush discards them. The flush also releases the halt, so software can start a new transfer. The block reports an empty indication, a queue level and three sticky event flags: refusal, drained and overflow. It also produces an interrupt from the drained flag, gated by an enable input.

Top module: `i2c_txq_nak`

## Requirements
- R1: The queue stores up to 64 bytes. A push (`wr_valid` high) is accepted when `fifo_en` is high, `flush` is low and the level before the clock edge is below 64. `fill_level` reports the number of stored bytes.
- R2: A push while `fifo_en` is low is ignored: the level and the flags do not change.
- R3: A push while the level before the edge is 64 is dropped and sets the overflow flag, `ovf_flag` (clear bit 2). The level test uses the occupancy before the edge, even if a byte leaves in the same cycle.
- R4: A flush empties the queue and resets the pointers in one cycle. It abandons the byte in progress (`eng_req` low in the next cycle), releases a halt and silently drops a push in the same cycle. A flush is not an overflow.
- R5: Bytes reach `eng_byte` in push order. When the drain is idle, `fifo_en` is high, the queue is not empty and no halt is active, `eng_req` rises in the next cycle with the head byte on `eng_byte`.
- R6: `eng_req` and `eng_byte` stay steady until `eng_done`. The byte leaves the queue on `eng_done`. `eng_req` is low in the cycle after `eng_done`, so the next byte is offered at the earliest one cycle later. `eng_done` while `eng_req` is low has no effect.
- R7: `eng_done` with `eng_nak` high consumes the byte and sets `nak_flag` (clear bit 0). No further byte is offered until a flush.
- R8: `tx_empty` is high exactly when `fill_level` is zero.
- R9: `empty_flag` (clear bit 1) is set when an acknowledged byte leaves a queue of level 1 and no push is accepted in the same cycle. `irq` is `empty_flag` AND `empty_ie`.
- R10: The flags are sticky. Each is cleared by its bit of `sts_clr`. A new event in the same cycle as its clear leaves the flag set.
- R11: With `fifo_en` low, no new byte is offered, but a byte already offered completes normally.
- R12: A synchronous active-low reset empties the queue, drops `eng_req` and clears all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | Queue mode enable |
| flush | input | 1 | Discard queue contents, release halt |
| wr_valid | input | 1 | Push strobe from the data write path |
| wr_data | input | 8 | Byte to push |
| empty_ie | input | 1 | Interrupt enable for the drained flag |
| sts_clr | input | 3 | Flag clear: bit0 refusal, bit1 drained, bit2 overflow |
| eng_done | input | 1 | Byte engine: acknowledge slot finished |
| eng_nak | input | 1 | Byte engine: target refused, valid with eng_done |
| eng_req | output | 1 | Byte offered to the engine |
| eng_byte | output | 8 | Byte being offered |
| tx_empty | output | 1 | Queue holds no bytes |
| fill_level | output | 7 | Number of stored bytes |
| nak_flag | output | 1 | Sticky refusal flag |
| empty_flag | output | 1 | Sticky drained flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Drained interrupt |

## Verification
Two functions can act in the same cycle: a push can be accepted while a byte is removed by `eng_done`, and a flush can meet a push or a completion. The random stimulus pushes often while the engine model completes bytes after short random delays and flushes at random. This makes a push coincide with the final pop at level 1, a push at level 64 coincide with a pop, and a flush collide with `eng_done`. Each outcome is judged against a bench model built from R1, R3, R4 and R9. The model predicts the exact level, whether the drained or overflow flag rises, and whether the next offered byte is correct.

// File: rtl/i2c_txq_pkg.sv
// Shared types for the I2C transmit queue.
// Assumes: the flag indexes are the bit positions of the sts_clr input.
package i2c_txq_pkg;
    typedef enum logic [1:0] {
        DR_IDLE = 2'd0,
        DR_BUSY = 2'd1,
        DR_HALT = 2'd2
    } drain_state_e;

    localparam int FLG_NAK   = 0;
    localparam int FLG_EMPTY = 1;
    localparam int FLG_OVF   = 2;
    localparam int NUM_FLAGS = 3;
endpackage

// File: rtl/txq_store.sv
// Circular byte store with a read pointer, a write pointer and an occupancy count.
// Assumes: push is never raised when full. A flush overrides push and pop.
module txq_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Write the pushed byte into the slot under the write pointer.
    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_ptr] <= wdata;
    end

    // Move the pointers and the count; a flush returns all of them to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= ptr_inc(wr_ptr);
            if (pop)  rd_ptr <= ptr_inc(rd_ptr);
            level <= level + CW'(push) - CW'(pop);
        end
    end

    // Present the oldest byte and the occupancy state.
    always_comb begin
        head  = mem[rd_ptr];
        full  = (level == CW'(DEPTH));
        empty = (level == '0);
    end

    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));
    assert_flush_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0));
    assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush) |-> (level != '0));
endmodule

// File: rtl/txq_drain.sv
// Drain sequencer: offers one byte at a time to the byte engine and waits for the
// end of its acknowledge slot. A refused byte halts the drain until a flush.
// Assumes: eng_nak is meaningful only together with eng_done.
module txq_drain
    import i2c_txq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          flush,
    input  logic          have_data,
    input  logic [DW-1:0] head,
    input  logic          eng_done,
    input  logic          eng_nak,
    output logic          eng_req,
    output logic [DW-1:0] eng_byte,
    output logic          pop,
    output logic          nak_evt
);
    drain_state_e state;

    // Step the drain state machine and latch the offered byte at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= DR_IDLE;
            eng_byte <= '0;
        end else if (flush) begin
            state <= DR_IDLE;
        end else begin
            unique case (state)
                DR_IDLE: if (fifo_en && have_data) begin
                    state    <= DR_BUSY;
                    eng_byte <= head;
                end
                DR_BUSY: if (eng_done) state <= eng_nak ? DR_HALT : DR_IDLE;
                DR_HALT: state <= DR_HALT;
                default: state <= DR_IDLE;
            endcase
        end
    end

    // Derive the request and the completion events from the state.
    always_comb begin
        eng_req = (state == DR_BUSY);
        pop     = eng_req && eng_done && !flush;
        nak_evt = pop && eng_nak;
    end

    assert_hold_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_done && !flush) |=> (eng_req && $stable(eng_byte)));
    assert_gap_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_done) |=> !eng_req);
    assert_halt_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DR_HALT && !flush) |=> !eng_req);
    assert_no_launch_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !eng_req) |=> !eng_req);
    assert_flush_abandons_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !eng_req);
endmodule

// File: rtl/txq_flags.sv
// Sticky event flags with per-bit clear. A set in the same cycle as its clear wins.
// Assumes: set and clr bits are single-cycle strobes.
module txq_flags #(
    parameter int NF = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    output logic [NF-1:0] flags
);
    for (genvar i = 0; i < NF; i++) begin : g_flag
        // Hold, clear or set one sticky flag.
        always_ff @(posedge clk) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= (flags[i] && !clr[i]) || set[i];
        end

        assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr[i]) |=> flags[i]);
        assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i]);
    end
endmodule

// File: rtl/i2c_txq_nak.sv
// I2C transmit byte queue: accepts pushes in queue mode, drains them in order to
// the byte engine, halts on a target refusal and reports level and sticky flags.
// Assumes: the byte engine holds eng_done for one cycle per offered byte.
module i2c_txq_nak
    import i2c_txq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fifo_en,
    input  logic                 flush,
    input  logic                 wr_valid,
    input  logic [DW-1:0]        wr_data,
    input  logic                 empty_ie,
    input  logic [NUM_FLAGS-1:0] sts_clr,
    input  logic                 eng_done,
    input  logic                 eng_nak,
    output logic                 eng_req,
    output logic [DW-1:0]        eng_byte,
    output logic                 tx_empty,
    output logic [CW-1:0]        fill_level,
    output logic                 nak_flag,
    output logic                 empty_flag,
    output logic                 ovf_flag,
    output logic                 irq
);
    logic          push_try, push_ok, ovf_evt, empty_evt;
    logic          pop, nak_evt, full, empty;
    logic [DW-1:0] head;
    logic [NUM_FLAGS-1:0] flag_set, flag_vec;

    // Decide whether a push is stored, dropped for overflow or ignored.
    always_comb begin
        push_try = fifo_en && wr_valid && !flush;
        push_ok  = push_try && !full;
        ovf_evt  = push_try && full;
    end

    txq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push_ok), .pop(pop), .flush(flush),
        .wdata(wr_data), .head(head), .level(fill_level), .full(full), .empty(empty)
    );

    txq_drain #(.DW(DW)) u_drain (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .flush(flush),
        .have_data(!empty), .head(head), .eng_done(eng_done), .eng_nak(eng_nak),
        .eng_req(eng_req), .eng_byte(eng_byte), .pop(pop), .nak_evt(nak_evt)
    );

    // Raise the drained event when an acknowledged byte empties the queue.
    always_comb begin
        empty_evt           = pop && !nak_evt && (fill_level == CW'(1)) && !push_ok;
        flag_set            = '0;
        flag_set[FLG_NAK]   = nak_evt;
        flag_set[FLG_EMPTY] = empty_evt;
        flag_set[FLG_OVF]   = ovf_evt;
    end

    txq_flags #(.NF(NUM_FLAGS)) u_flags (
        .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(sts_clr), .flags(flag_vec)
    );

    // Map the flag vector onto the status outputs and the interrupt.
    always_comb begin
        nak_flag   = flag_vec[FLG_NAK];
        empty_flag = flag_vec[FLG_EMPTY];
        ovf_flag   = flag_vec[FLG_OVF];
        tx_empty   = empty;
        irq        = empty_flag && empty_ie;
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_try && !pop) |=> (fill_level == CW'(DEPTH)));
    assert_ignored_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !eng_req && !flush) |=> $stable(fill_level));
    assert_empty_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty == (fill_level == '0));
endmodule

// File: tb/tb_i2c_txq_nak.sv
module tb_i2c_txq_nak;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       fifo_en, flush, wr_valid, empty_ie, eng_done, eng_nak;
    logic [7:0] wr_data;
    logic [2:0] sts_clr;
    logic       eng_req, tx_empty, nak_flag, empty_flag, ovf_flag, irq;
    logic [7:0] eng_byte;
    logic [6:0] fill_level;

    int vectors = 0;
    int fails   = 0;

    always #2 clk = ~clk;

    i2c_txq_nak dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .flush(flush),
        .wr_valid(wr_valid), .wr_data(wr_data), .empty_ie(empty_ie),
        .sts_clr(sts_clr), .eng_done(eng_done), .eng_nak(eng_nak),
        .eng_req(eng_req), .eng_byte(eng_byte), .tx_empty(tx_empty),
        .fill_level(fill_level), .nak_flag(nak_flag), .empty_flag(empty_flag),
        .ovf_flag(ovf_flag), .irq(irq)
    );

    // Reference model state, built from the requirements.
    logic [7:0] mq [64];
    int  m_cnt, m_wr, m_rd, delay;
    bit  m_busy, m_halt, m_nakf, m_empf, m_ovff;
    logic [7:0] m_byte;

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R8 tx_empty", int'(tx_empty), int'(m_cnt == 0));
        chk("R1/R2/R3/R4 fill_level", int'(fill_level), m_cnt);
        chk("R5/R6/R7/R11 eng_req", int'(eng_req), int'(m_busy));
        if (m_busy) chk("R5 eng_byte", int'(eng_byte), int'(m_byte));
        chk("R7/R10 nak_flag", int'(nak_flag), int'(m_nakf));
        chk("R9/R10 empty_flag", int'(empty_flag), int'(m_empf));
        chk("R3/R10 ovf_flag", int'(ovf_flag), int'(m_ovff));
        chk("R9 irq", int'(irq), int'(m_empf && empty_ie));
    endtask

    // Advance the model across one clock edge with the inputs now driven.
    task automatic model_step();
        bit push_try, acc, ovfe, done, nake, empe;
        int cnt_old, rd_old;
        cnt_old  = m_cnt;
        rd_old   = m_rd;
        push_try = fifo_en && wr_valid && !flush;
        acc      = push_try && (cnt_old < 64);
        ovfe     = push_try && (cnt_old == 64);
        done     = m_busy && eng_done && !flush;
        nake     = done && eng_nak;
        empe     = done && !eng_nak && (cnt_old == 1) && !acc;
        if (flush) begin
            m_cnt = 0; m_wr = 0; m_rd = 0; m_busy = 0; m_halt = 0;
        end else begin
            if (acc) begin mq[m_wr] = wr_data; m_wr = (m_wr + 1) % 64; end
            if (done) m_rd = (m_rd + 1) % 64;
            m_cnt = cnt_old + int'(acc) - int'(done);
            if (m_busy) begin
                if (eng_done) begin m_busy = 0; m_halt = eng_nak; end
            end else if (!m_halt && fifo_en && cnt_old > 0) begin
                m_busy = 1; m_byte = mq[rd_old];
            end
        end
        m_nakf = (m_nakf && !sts_clr[0]) || nake;
        m_empf = (m_empf && !sts_clr[1]) || empe;
        m_ovff = (m_ovff && !sts_clr[2]) || ovfe;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; fifo_en = 0; flush = 0; wr_valid = 0; wr_data = 0;
        empty_ie = 0; sts_clr = 0; eng_done = 0; eng_nak = 0;
        m_cnt = 0; m_wr = 0; m_rd = 0; m_busy = 0; m_halt = 0;
        m_nakf = 0; m_empf = 0; m_ovff = 0; m_byte = 0; delay = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R12: reset state.
        chk("R12 reset empty", int'(tx_empty), 1);
        chk("R12 reset level", int'(fill_level), 0);
        chk("R12 reset req", int'(eng_req), 0);
        chk("R12 reset flags", int'({nak_flag, empty_flag, ovf_flag}), 0);

        for (int cyc = 0; cyc < 40000; cyc++) begin
            @(negedge clk);
            compare_all();
            flush = 0; sts_clr = 0; eng_done = 0; eng_nak = 0;
            if (cyc < 150) begin
                // Directed: fill past 64 with the engine stalled (R3 overflow).
                fifo_en  = 1;
                wr_valid = ($urandom % 10) != 0;
                wr_data  = 8'($urandom);
            end else if (cyc == 150) begin
                // Directed: flush a full queue with a byte in flight (R4).
                flush = 1; wr_valid = 1; wr_data = 8'hA5;
            end else if (cyc < 400) begin
                // Directed: queue mode off, pushes ignored (R2), no launch (R11).
                fifo_en  = (cyc < 160);
                wr_valid = ($urandom % 2) == 0;
                wr_data  = 8'($urandom);
                sts_clr  = (cyc == 300) ? 3'b111 : 3'b000;
            end else begin
                fifo_en  = (cyc % 900) < 780;
                empty_ie = (cyc % 1400) < 700;
                wr_valid = ($urandom % 5) < 2;
                wr_data  = 8'($urandom);
                flush    = (($urandom % 150) == 0) || (m_halt && ($urandom % 12) == 0);
                for (int b = 0; b < 3; b++) sts_clr[b] = ($urandom % 25) == 0;
                if (eng_req) begin
                    if (delay == 0) begin
                        eng_done = 1;
                        eng_nak  = ($urandom % 14) == 0;
                        delay    = int'($urandom % 4);
                    end else begin
                        delay--;
                    end
                end else begin
                    // R6: a stray completion while nothing is offered has no effect.
                    eng_done = ($urandom % 20) == 0;
                    eng_nak  = ($urandom % 2) == 0;
                end
            end
            model_step();
        end
        @(negedge clk);
        compare_all();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule